// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the target side of a two-wire serial bus (SCL clock, SDA data) used to load a device's configuration. It holds 26 byte-wide registers and presents all of them as one flat output bus for the device logic to use. A system clock much faster than SCL samples both bus lines. The block detects start and stop conditions, recognises its own 7-bit address, acknowledges bytes and shifts data out on reads. It never stretches the clock, and SDA is only ever pulled low through an output enable.

A write transfer sends the device address, then one byte that sets an internal register pointer. The pointer itself cannot be read. Any further bytes are stored at the pointer, and the pointer advances after each byte. A read transfer returns bytes from the current pointer and also advances it. Two cases run past the last register. A write beyond it is refused. A read beyond it keeps returning the last register.

Top module: `i2c_regfile_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high, both judged after synchronisation. A stop at any point returns the block to idle. A start at any point begins a new address phase. In both cases a byte partly received is dropped and no register changes.
- R2: The address byte is sent MSB first: seven address bits, then R/W, where 1 means read. The address is `DEV_ADDR[6:1]` followed by the `addr_sel` pin as its LSB. The block pulls SDA low during the ninth clock only when the address matches. On a mismatch it does not drive SDA and goes idle.
- R3: In a write, the first byte after the address loads the pointer. Values 0 to 25 are acknowledged. A value of 26 or more gets no acknowledge, sends the block idle and leaves the pointer unchanged.
- R4: Each further write byte is stored at the pointer and acknowledged, and then the pointer advances by one.
- R5: After register 25 has been written, the next write byte gets no acknowledge. That byte is discarded and the block goes idle.
- R6: A read returns the register at the pointer, MSB first, and advances the pointer after each byte. The pointer stays at 25 once it reaches it, so register 25 repeats. A master acknowledge continues the read, and a master no-acknowledge ends it. The pointer is kept from one transfer to the next.
- R7: At reset, registers 7, 8, 9 and 10 hold 0x16, 0x7C, 0xF0 and 0x21, which is the 32-bit value 0x21F07C16 stored low byte first. Register 4 holds 0x10, with bit 4 as the pedestal enable. Every other register holds 0.
- R8: SDA is open-drain. `sda_oe` high pulls the line low. `sda_oe` only rises while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| addr_sel | input | 1 | Sets the LSB of the device address |
| sda_oe | output | 1 | When high, pulls SDA low |
| reg_bus | output | 208 | All registers; register i sits at bits 8i+7 down to 8i |

## Verification
The hardest cases to reach are the edges of the pointer. One is a write that runs past register 25, where the third byte must be refused while the first two are kept. The other is a read burst that starts at register 24 and must return register 25 repeatedly. The bench sets the pointer to 24 and drives bursts longer than the space left in the register file, so it reaches both. It also stops a byte after four bits, and restarts another after three bits. It then reads the whole register bus to show that nothing was written.

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter int          NUM_REGS  = 26,
  parameter logic [6:0]  DEV_ADDR  = 7'h2A,
  parameter int          FSC_BASE  = 7,
  parameter logic [31:0] FSC_RESET = 32'h21F07C16,
  parameter int          PED_REG   = 4,
  parameter int          PED_BIT   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  addr_sel,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] reg_bus
);

  localparam int PTR_W = $clog2(NUM_REGS);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(NUM_REGS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_SUB, S_SACK, S_WDATA, S_WACK, S_RDATA, S_RACK
  } state_t;

  function automatic logic [7:0] init_val(int idx);
    logic [7:0] v;
    v = 8'h00;
    if (idx >= FSC_BASE && idx < FSC_BASE + 4) v = FSC_RESET[8*(idx-FSC_BASE) +: 8];
    if (idx == PED_REG) v[PED_BIT] = 1'b1;
    return v;
  endfunction

  logic [2:0] scl_p, sda_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  logic scl_s, scl_d, sda_s, sda_d;
  assign scl_s = scl_p[1];
  assign scl_d = scl_p[2];
  assign sda_s = sda_p[1];
  assign sda_d = sda_p[2];

  logic scl_rise, scl_fall, start_evt, stop_evt;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

  state_t           state;
  logic [3:0]       cnt;
  logic [7:0]       sr, tx;
  logic [PTR_W-1:0] ptr;
  logic             ovf, rw;
  logic [7:0]       regs [NUM_REGS];

  logic byte_end, wr_fire;
  assign byte_end = scl_fall && (cnt == 4'd8);
  assign wr_fire  = (state == S_WDATA) && byte_end && !ovf && !start_evt && !stop_evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= init_val(i);
    end else if (wr_fire) begin
      regs[ptr] <= sr;
    end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bus
    assign reg_bus[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sr     <= '0;
      tx     <= '0;
      ptr    <= '0;
      ovf    <= 1'b0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      state  <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_SUB, S_WDATA: begin
          if (scl_rise) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            if (state == S_ADDR) begin
              if (sr[7:1] == {DEV_ADDR[6:1], addr_sel}) begin
                rw     <= sr[0];
                sda_oe <= 1'b1;
                state  <= S_AACK;
              end else state <= S_IDLE;
            end else if (state == S_SUB) begin
              if (int'(sr) < NUM_REGS) begin
                ptr    <= sr[PTR_W-1:0];
                ovf    <= 1'b0;
                sda_oe <= 1'b1;
                state  <= S_SACK;
              end else state <= S_IDLE;
            end else begin
              if (ovf) state <= S_IDLE;
              else begin
                sda_oe <= 1'b1;
                state  <= S_WACK;
                if (ptr == TOP) ovf <= 1'b1;
                else            ptr <= ptr + 1'b1;
              end
            end
          end
        end
        S_AACK: if (scl_fall) begin
          cnt <= '0;
          if (rw) begin
            tx     <= regs[ptr];
            sda_oe <= ~regs[ptr][7];
            state  <= S_RDATA;
          end else begin
            sda_oe <= 1'b0;
            state  <= S_SUB;
          end
        end
        S_SACK, S_WACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          cnt    <= '0;
          state  <= S_WDATA;
        end
        S_RDATA: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (byte_end) begin
            sda_oe <= 1'b0;
            state  <= S_RACK;
            if (ptr != TOP) ptr <= ptr + 1'b1;
          end else if (scl_fall) begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
        S_RACK: begin
          if (scl_rise && sda_s) state <= S_IDLE;
          else if (scl_fall) begin
            tx     <= regs[ptr];
            sda_oe <= ~regs[ptr][7];
            cnt    <= '0;
            state  <= S_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

module i2c_regfile_slave_chk #(
  parameter int NUM_REGS = 26,
  parameter int PTR_W    = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  scl_fall,
  input logic                  stop_evt,
  input logic                  sda_oe,
  input logic [PTR_W-1:0]      ptr,
  input logic [NUM_REGS*8-1:0] reg_bus
);

  assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  assert_drive_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_write_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_bus) |-> $past(scl_fall));

  assert_ptr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < NUM_REGS);

endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall), .stop_evt(stop_evt),
  .sda_oe(sda_oe), .ptr(ptr), .reg_bus(reg_bus)
);

// File: tb/i2c_regfile_slave_test.sv
module i2c_regfile_slave_test;
  localparam int N  = 26;
  localparam int Q  = 8;
  localparam logic [7:0] AW = 8'h54, AR = 8'h55;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1, addr_sel = 0;
  logic sda_oe;
  logic [N*8-1:0] reg_bus;
  wire sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_regfile_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .reg_bus(reg_bus)
  );

  int tests = 0, fails = 0, drive_viol = 0;
  logic [7:0] model [N];
  logic oe_prev = 0;

  always @(negedge clk) begin
    if (sda_oe && !oe_prev && scl_m) drive_viol++;
    oe_prev <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; tick(Q); scl_m = 1; tick(Q); s = sda_bus; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, ack);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      b = {b[6:0], s};
    end
    clk_bit(nack, s);
  endtask

  task automatic check_regs(input string req);
    int bad = 0;
    for (int i = 0; i < N; i++)
      if (reg_bus[i*8 +: 8] !== model[i]) begin
        bad++;
        check(1'b0, req, reg_bus[i*8 +: 8], model[i]);
      end
    if (bad == 0) check(1'b1, req, 0, 0);
  endtask

  task automatic set_ptr(input logic [7:0] sub, output logic a0, output logic a1);
    bus_start(); send_byte(AW, a0); send_byte(sub, a1);
  endtask

  localparam logic [15:0] VEC [6] = '{
    {8'd0, 8'hA5}, {8'd3, 8'h3C}, {8'd7, 8'h00}, {8'd12, 8'hFF}, {8'd19, 8'h81}, {8'd25, 8'h5E}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] rd, rd1, rd2, rd3;
    for (int i = 0; i < N; i++) model[i] = 8'h00;
    model[7] = 8'h16; model[8] = 8'h7C; model[9] = 8'hF0; model[10] = 8'h21;
    model[4] = 8'h10;

    tick(5); rst_n = 1; tick(5);
    // R7 reset values
    check_regs("R7");
    check(sda_oe == 1'b0, "R8 idle release", sda_oe, 0);

    // R2 R3 R4 R6 table: write one byte, read it back
    foreach (VEC[k]) begin
      set_ptr(VEC[k][15:8], a0, a1); send_byte(VEC[k][7:0], a2); bus_stop();
      model[VEC[k][15:8]] = VEC[k][7:0];
      check({a0, a1, a2} == 3'b000, "R2/R3/R4 acks", {a0, a1, a2}, 0);
      set_ptr(VEC[k][15:8], a0, a1); bus_start(); send_byte(AR, a2); recv_byte(1'b1, rd); bus_stop();
      check(rd == VEC[k][7:0], "R6 readback", rd, VEC[k][7:0]);
    end
    check_regs("R4 table");

    // R4 burst write with pointer increment
    set_ptr(8'd2, a0, a1); send_byte(8'h11, a1); send_byte(8'h22, a2); send_byte(8'h33, a3); bus_stop();
    model[2] = 8'h11; model[3] = 8'h22; model[4] = 8'h33;
    check({a1, a2, a3} == 3'b000, "R4 burst acks", {a1, a2, a3}, 0);
    check_regs("R4 burst");

    // R6 burst read
    set_ptr(8'd2, a0, a1); bus_start(); send_byte(AR, a2);
    recv_byte(1'b0, rd); recv_byte(1'b0, rd1); recv_byte(1'b0, rd2); recv_byte(1'b1, rd3); bus_stop();
    check({rd, rd1, rd2, rd3} == {8'h11, 8'h22, 8'h33, model[5]}, "R6 burst read",
          {rd, rd1, rd2, rd3}, {8'h11, 8'h22, 8'h33, model[5]});

    // R5 write overrun
    set_ptr(8'd24, a0, a1); send_byte(8'h5A, a1); send_byte(8'h6B, a2); send_byte(8'h7C, a3); bus_stop();
    model[24] = 8'h5A; model[25] = 8'h6B;
    check({a1, a2, a3} == 3'b001, "R5 overrun nack", {a1, a2, a3}, 1);
    check_regs("R5 discard");

    // R6 read past top repeats top
    set_ptr(8'd24, a0, a1); bus_start(); send_byte(AR, a2);
    recv_byte(1'b0, rd); recv_byte(1'b0, rd1); recv_byte(1'b0, rd2); recv_byte(1'b1, rd3); bus_stop();
    check({rd, rd1, rd2, rd3} == 32'h5A6B6B6B, "R6 top repeat", {rd, rd1, rd2, rd3}, 32'h5A6B6B6B);

    // R3 invalid subaddress
    set_ptr(8'd26, a0, a1); bus_stop();
    check(a1 == 1'b1, "R3 sub 26 nack", a1, 1);
    set_ptr(8'hFF, a0, a1); bus_stop();
    check(a1 == 1'b1, "R3 sub FF nack", a1, 1);
    bus_start(); send_byte(AR, a2); recv_byte(1'b1, rd); bus_stop();
    check(rd == 8'h6B, "R3 pointer kept", rd, 8'h6B);

    // R2 address select
    bus_start(); send_byte(8'h56, a0); bus_stop();
    check(a0 == 1'b1, "R2 mismatch nack", a0, 1);
    addr_sel = 1; tick(Q);
    bus_start(); send_byte(8'h56, a0); send_byte(8'd0, a1); send_byte(8'h99, a2); bus_stop();
    model[0] = 8'h99;
    check({a0, a1, a2} == 3'b000, "R2 sel=1 acks", {a0, a1, a2}, 0);
    bus_start(); send_byte(AW, a0); bus_stop();
    check(a0 == 1'b1, "R2 old addr nack", a0, 1);
    addr_sel = 0; tick(Q);
    check_regs("R2 regs");

    // R1 stop mid-byte
    set_ptr(8'd1, a0, a1);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, a2);
    bus_stop();
    check_regs("R1 stop mid-byte");

    // R1 start mid-byte starts new address phase
    set_ptr(8'd1, a0, a1);
    for (int i = 0; i < 3; i++) clk_bit(1'b0, a2);
    bus_start(); send_byte(AW, a0); send_byte(8'd1, a1); send_byte(8'h42, a2); bus_stop();
    model[1] = 8'h42;
    check({a0, a1, a2} == 3'b000, "R1 restart acks", {a0, a1, a2}, 0);
    check_regs("R1 restart regs");

    check(drive_viol == 0, "R8 drive while scl high", drive_viol, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule